// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a small fixed-point signal processor. It holds two 16-bit operand registers (X and Y), a 32-bit product register (P) and a 32-bit accumulator (A). The product is always twice the signed product of its two operands, which keeps Q15 × Q15 results aligned as Q31. Writing either operand register refreshes P on the next clock edge without any explicit multiply command.

Three decoded operation strobes take their operands straight from the two RAM operand buses.

- **Load-multiply** clears A and loads P.
- **Multiply-accumulate** adds the old P into A and reloads P in the same cycle.
- **Multiply-subtract** does the same, but subtracts the old P from A.

A separate strobe copies the whole of P into A. The accumulator is seen as a high word, which is the normal register view, and a low word, which has its own register.

Three flags sit in a 16-bit status word and track accumulator results:

- negative,
- overflow,
- a carry/borrow flag.

Instruction decode, the pointer RAM and sequencing live outside this block.

Top module: `fmac_datapath`

## Requirements
- R1: While rst_n is low at a clock edge, X, Y, P and A become zero and the status word becomes zero.
- R2: A write to X (x_we) or Y (y_we) with op_code 00 makes P equal to 2·X·Y on the next edge. X and Y are signed 16-bit; each takes its new value if written, otherwise the held value.
- R3: The one case -32768 × -32768 makes P = 0x7FFFFFFF and sets the overflow flag (status bit 14), whether it comes from X/Y writes or from RAM operands.
- R4: op_code 01 (load-multiply) sets A to 0 and P to 2·ram_a·ram_b. It clears negative (bit 15) and carry (bit 12), and sets overflow only when the new product saturates.
- R5: op_code 10 (multiply-accumulate) sets A to A + P_old, wrapping in 32 bits, and P to 2·ram_a·ram_b, all in one edge.
- R6: op_code 11 (multiply-subtract) sets A to A − P_old, wrapping in 32 bits, and P to 2·ram_a·ram_b.
- R7: After op_codes 10 and 11, the flags are set as follows:
  - bit 15 = A[31];
  - bit 14 = signed overflow of the add or subtract, ORed with product saturation;
  - bit 12 = unsigned carry out for add, or borrow (A_old < P_old unsigned) for subtract.
  All other status bits read 0.
- R8: move_p (with op_code 00) copies the full 32-bit P into A. It sets bit 15 to P[31] and clears bit 12. Bit 14 becomes 1 only if an X/Y write in the same cycle saturates.
- R9: acc_hi always shows A[31:16] and acc_lo shows A[15:0].
- R10: A write aimed at P (p_we with p_wdata) never changes P.
- R11: When op_code is not 00, P is loaded from the RAM operands even if X or Y is written in the same cycle. The written X/Y value is still stored and is used by the next X/Y-triggered refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_we | input | 1 | Write strobe for X |
| x_wdata | input | 16 | New X value |
| y_we | input | 1 | Write strobe for Y |
| y_wdata | input | 16 | New Y value |
| op_code | input | 2 | 00 idle, 01 load-multiply, 10 multiply-accumulate, 11 multiply-subtract |
| ram_a | input | 16 | First RAM operand |
| ram_b | input | 16 | Second RAM operand |
| move_p | input | 1 | Copy P into A |
| p_we | input | 1 | Write attempt aimed at P (ignored) |
| p_wdata | input | 32 | Data of the ignored P write |
| p_out | output | 32 | Product register |
| acc_hi | output | 16 | Accumulator high word |
| acc_lo | output | 16 | Accumulator low word |
| status | output | 16 | Flags: bit 15 negative, bit 14 overflow, bit 12 carry |

## Verification
The operand stimulus falls into four groups, each separating one class of fault:

- **Single-register writes of X, then Y:** show that the held value of the other register enters the product.
- **Mixed-sign operand pairs:** separate signed from unsigned multiplication.
- **The doubled 0x4000 × 0x4000 case:** exposes a missing doubling.
- **The -32768 × -32768 pair, from both sources:** isolates the saturation path.

The accumulate and subtract steps use a chain of results that makes the fused ordering visible: a design that reloaded P before adding it would leave a different A. The chain also drives the 32-bit boundary, giving a carry out, a signed overflow and a borrow. Simultaneous operation and X write, ignored P writes, and idle cycles with nothing strobed check priority and that state is held.

// File: rtl/fmac_pkg.sv
// Shared constants for the fractional multiply-accumulate datapath.
// Assumes 16-bit operands and a status word whose flag positions are
// decoded by neighbouring logic, so the bit indices are fixed here.
package fmac_pkg;
    localparam int DATA_W = 16;
    localparam int ACC_W  = 2 * DATA_W;

    localparam int STAT_W     = 16;
    localparam int STAT_NEG   = 15;
    localparam int STAT_OVF   = 14;
    localparam int STAT_CARRY = 12;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LDM  = 2'b01,
        OP_MAC  = 2'b10,
        OP_MSB  = 2'b11
    } fmac_op_e;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic carry;
    } fmac_flags_t;
endpackage

// File: rtl/fmac_mul.sv
// Doubled signed multiplier: prod = 2 * a * b in W2 bits.
// Assumes two's complement operands; the only unrepresentable case,
// most-negative times most-negative, saturates and raises sat.
module fmac_mul #(
    parameter int W = 16,
    localparam int W2 = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W2-1:0] prod,
    output logic          sat
);
    localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W2-1:0] MOST_POS = {1'b0, {(W2-1){1'b1}}};

    logic signed [W2-1:0] raw;

    // Form the signed product, then shift left one place or clamp.
    always_comb begin
        raw  = W2'($signed(a) * $signed(b));
        sat  = (a == MOST_NEG) && (b == MOST_NEG);
        prod = sat ? MOST_POS : {raw[W2-2:0], 1'b0};
    end
endmodule

// File: rtl/fmac_addsub.sv
// Accumulator adder/subtractor with flag generation.
// Result wraps in W bits; carry is the unsigned carry out for add and
// the borrow (a < b unsigned) for subtract; ovf is signed overflow.
module fmac_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);
    logic [W:0] ext;

    // Widen by one bit so the top bit carries the carry or borrow.
    always_comb begin
        ext   = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        res   = ext[W-1:0];
        carry = ext[W];
        if (sub) ovf = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
        else     ovf = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/fmac_datapath.sv
// Fractional multiply-accumulate datapath (top).
// Holds X, Y, the doubled product P and the 32-bit accumulator A.
// Assumes decoded strobes: op_code selects an operation on the RAM
// operands (it has priority over X/Y-triggered refresh of P), move_p
// copies P into A when no operation runs, and p_we is dropped because
// P has no direct write path.
module fmac_datapath
    import fmac_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_we,
    input  logic [DW-1:0] x_wdata,
    input  logic          y_we,
    input  logic [DW-1:0] y_wdata,
    input  logic [1:0]    op_code,
    input  logic [DW-1:0] ram_a,
    input  logic [DW-1:0] ram_b,
    input  logic          move_p,
    input  logic          p_we,
    input  logic [AW-1:0] p_wdata,
    output logic [AW-1:0] p_out,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo,
    output logic [STAT_W-1:0] status
);
    fmac_op_e      op;
    logic [DW-1:0] x_q, y_q, x_nx, y_nx;
    logic [AW-1:0] p_q, acc_q;
    fmac_flags_t   flg_q;

    logic [DW-1:0] mul_a [2];
    logic [DW-1:0] mul_b [2];
    logic [AW-1:0] mul_p [2];
    logic          mul_s [2];

    logic [AW-1:0] as_res;
    logic          as_carry, as_ovf;
    logic          p_ignored;

    // Decode the op and form the next operand values (write-through).
    always_comb begin
        op        = fmac_op_e'(op_code);
        x_nx      = x_we ? x_wdata : x_q;
        y_nx      = y_we ? y_wdata : y_q;
        mul_a[0]  = ram_a;
        mul_b[0]  = ram_b;
        mul_a[1]  = x_nx;
        mul_b[1]  = y_nx;
        p_ignored = p_we & (|p_wdata | 1'b1);
    end

    // Two multipliers: index 0 serves RAM operands, index 1 serves X/Y.
    for (genvar g = 0; g < 2; g++) begin : g_mul
        fmac_mul #(.W(DW)) u_mul (
            .a    (mul_a[g]),
            .b    (mul_b[g]),
            .prod (mul_p[g]),
            .sat  (mul_s[g])
        );
    end

    fmac_addsub #(.W(AW)) u_addsub (
        .a     (acc_q),
        .b     (p_q),
        .sub   (op == OP_MSB),
        .res   (as_res),
        .carry (as_carry),
        .ovf   (as_ovf)
    );

    // Operand registers: store every write, whatever else happens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= x_nx;
            y_q <= y_nx;
        end
    end

    // Product register: RAM product on an op, else X/Y refresh on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 p_q <= '0;
        else if (op != OP_IDLE)     p_q <= mul_p[0];
        else if (x_we || y_we)      p_q <= mul_p[1];
    end

    // Accumulator and flags for operations, moves and product saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            flg_q <= '0;
        end else begin
            unique case (op)
                OP_LDM: begin
                    acc_q <= '0;
                    flg_q <= '{neg: 1'b0, ovf: mul_s[0], carry: 1'b0};
                end
                OP_MAC, OP_MSB: begin
                    acc_q <= as_res;
                    flg_q <= '{neg: as_res[AW-1], ovf: as_ovf | mul_s[0],
                               carry: as_carry};
                end
                default: begin
                    if (move_p) begin
                        acc_q <= p_q;
                        flg_q <= '{neg: p_q[AW-1],
                                   ovf: (x_we | y_we) & mul_s[1],
                                   carry: 1'b0};
                    end else if ((x_we || y_we) && mul_s[1]) begin
                        flg_q.ovf <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Output views of the registers.
    always_comb begin
        p_out              = p_q;
        acc_hi             = acc_q[AW-1:DW];
        acc_lo             = acc_q[DW-1:0];
        status             = '0;
        status[STAT_NEG]   = flg_q.neg;
        status[STAT_OVF]   = flg_q.ovf;
        status[STAT_CARRY] = flg_q.carry;
    end

    logic unused_ok;
    assign unused_ok = p_ignored;
endmodule

// File: rtl/fmac_datapath_checker.sv
// Temporal checks for fmac_datapath, attached with bind.
// Observes ports only; all properties are disabled during reset.
module fmac_datapath_checker
    import fmac_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          x_we,
    input logic [15:0]   x_wdata,
    input logic          y_we,
    input logic [15:0]   y_wdata,
    input logic [1:0]    op_code,
    input logic          move_p,
    input logic          p_we,
    input logic [31:0]   p_out,
    input logic [15:0]   acc_hi,
    input logic [15:0]   acc_lo,
    input logic [15:0]   status
);
    logic [31:0] acc;
    assign acc = {acc_hi, acc_lo};

    assert_p_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we && op_code == 2'b00 && !x_we && !y_we) |=> $stable(p_out));

    assert_load_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b01) |=> (acc == 32'h0 && !status[STAT_NEG] && !status[STAT_CARRY]));

    assert_mac_adds_old_p_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b10) |=> (acc == $past(acc) + $past(p_out)));

    assert_msb_subs_old_p_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b11) |=> (acc == $past(acc) - $past(p_out)));

    assert_neg_follows_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code[1]) |=> (status[STAT_NEG] == acc_hi[15]));

    assert_move_copies_p_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b00 && move_p) |=> (acc == $past(p_out) && !status[STAT_CARRY]));

    assert_xy_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b00 && x_we && y_we && x_wdata == 16'h8000 && y_wdata == 16'h8000)
        |=> (p_out == 32'h7FFF_FFFF && status[STAT_OVF]));
endmodule

bind fmac_datapath fmac_datapath_checker u_fmac_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_we    (x_we),
    .x_wdata (x_wdata),
    .y_we    (y_we),
    .y_wdata (y_wdata),
    .op_code (op_code),
    .move_p  (move_p),
    .p_we    (p_we),
    .p_out   (p_out),
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo),
    .status  (status)
);

// File: tb/fmac_datapath_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one stimulus per cycle and pushes
// the result predicted from the requirements; the monitor pops and
// compares it just after the edge that registers the result.
module fmac_datapath_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x_we = 1'b0, y_we = 1'b0, move_p = 1'b0, p_we = 1'b0;
    logic [15:0] x_wdata = '0, y_wdata = '0, ram_a = '0, ram_b = '0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] p_wdata = '0;
    logic [31:0] p_out;
    logic [15:0] acc_hi, acc_lo, status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] p;
        logic [31:0] a;
        logic [15:0] st;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // Reference model state
    logic [15:0] mx = '0, my = '0;
    logic [31:0] mp = '0, ma = '0;
    logic        mn = 1'b0, mv = 1'b0, mc = 1'b0;

    always #5 clk = ~clk;

    fmac_datapath uut (
        .clk(clk), .rst_n(rst_n),
        .x_we(x_we), .x_wdata(x_wdata), .y_we(y_we), .y_wdata(y_wdata),
        .op_code(op_code), .ram_a(ram_a), .ram_b(ram_b),
        .move_p(move_p), .p_we(p_we), .p_wdata(p_wdata),
        .p_out(p_out), .acc_hi(acc_hi), .acc_lo(acc_lo), .status(status)
    );

    function automatic logic [32:0] dmul(input logic [15:0] a, input logic [15:0] b);
        longint s;
        if (a == 16'h8000 && b == 16'h8000) return {1'b1, 32'h7FFF_FFFF};
        s = longint'($signed(a)) * longint'($signed(b)) * 2;
        return {1'b0, s[31:0]};
    endfunction

    task automatic step(input logic [1:0] op, input logic [15:0] ra, input logic [15:0] rb,
                        input logic xw, input logic [15:0] xd, input logic yw, input logic [15:0] yd,
                        input logic mvp, input logic pw, input logic [31:0] pd, input string tag);
        logic [15:0] nx, ny;
        logic [32:0] r, q;
        logic [32:0] e;
        exp_t it;
        @(negedge clk);
        op_code = op; ram_a = ra; ram_b = rb; x_we = xw; x_wdata = xd;
        y_we = yw; y_wdata = yd; move_p = mvp; p_we = pw; p_wdata = pd;
        nx = xw ? xd : mx;
        ny = yw ? yd : my;
        r = dmul(ra, rb);
        q = dmul(nx, ny);
        case (op)
            2'b01: begin ma = 0; mn = 0; mc = 0; mv = r[32]; mp = r[31:0]; end
            2'b10: begin
                e = {1'b0, ma} + {1'b0, mp};
                mv = ((ma[31] == mp[31]) && (e[31] != ma[31])) || r[32];
                mc = e[32]; ma = e[31:0]; mn = ma[31]; mp = r[31:0];
            end
            2'b11: begin
                e = {1'b0, ma} - {1'b0, mp};
                mv = ((ma[31] != mp[31]) && (e[31] != ma[31])) || r[32];
                mc = (ma < mp); ma = e[31:0]; mn = ma[31]; mp = r[31:0];
            end
            default: begin
                if (mvp) begin
                    ma = mp; mn = mp[31]; mc = 0; mv = (xw || yw) && q[32];
                end else if ((xw || yw) && q[32]) mv = 1;
                if (xw || yw) mp = q[31:0];
            end
        endcase
        mx = nx; my = ny;
        it.p = mp; it.a = ma; it.st = {mn, mv, 1'b0, mc, 12'h000}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(2'b00, 16'h0, 16'h0, 0, 16'h0, 0, 16'h0, 0, 0, 32'h0, tag);
    endtask

    // Monitor: compare the oldest prediction just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (p_out !== it.p || {acc_hi, acc_lo} !== it.a || status !== it.st) begin
                    fails++;
                    $display("FAIL %s: p=%h acc=%h st=%h expected p=%h acc=%h st=%h",
                             it.tag, p_out, {acc_hi, acc_lo}, status, it.p, it.a, it.st);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with inputs strobed during reset
        x_we = 1'b1; x_wdata = 16'h1234; op_code = 2'b01; ram_a = 16'h7; ram_b = 16'h9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (p_out !== 32'h0 || acc_hi !== 16'h0 || acc_lo !== 16'h0 || status !== 16'h0) begin
            fails++;
            $display("FAIL R1: p=%h acc=%h%h st=%h expected all zero", p_out, acc_hi, acc_lo, status);
        end
        x_we = 1'b0; op_code = 2'b00;
        rst_n = 1'b1;

        step(2'b00, 0, 0, 1, 16'd3, 0, 0, 0, 0, 0, "R2 X only, Y held at 0");
        step(2'b00, 0, 0, 0, 0, 1, 16'd5, 0, 0, 0, "R2 Y only, X held");
        step(2'b00, 0, 0, 1, 16'hFFFC, 1, 16'd7, 0, 0, 0, "R2 signed mixed");
        step(2'b00, 0, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF, "R10 P write ignored");
        step(2'b00, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8 R9 move P to A");
        step(2'b10, 16'h4000, 16'h4000, 0, 0, 0, 0, 0, 0, 0, "R5 R7 mac carry out");
        step(2'b11, 16'd2, 16'd3, 0, 0, 0, 0, 0, 0, 0, "R6 R7 msb");
        step(2'b01, 16'h8000, 16'h8000, 0, 0, 0, 0, 0, 0, 0, "R3 R4 load saturates");
        step(2'b10, 16'd1, 16'd1, 0, 0, 0, 0, 0, 0, 0, "R5 mac of saturated P");
        step(2'b10, 16'd0, 16'd0, 0, 0, 0, 0, 0, 1, 32'h1, "R7 signed overflow");
        step(2'b01, 16'h0100, 16'h0100, 0, 0, 0, 0, 0, 0, 0, "R4 load clears");
        step(2'b11, 16'hFFFF, 16'd5, 0, 0, 0, 0, 0, 0, 0, "R7 borrow on msb");
        step(2'b01, 16'd1, 16'd2, 1, 16'd9, 0, 0, 0, 0, 0, "R11 op wins over X write");
        step(2'b00, 0, 0, 0, 0, 1, 16'd1, 0, 0, 0, "R11 stored X used");
        step(2'b00, 0, 0, 1, 16'h8000, 1, 16'h8000, 0, 0, 0, "R3 X/Y saturation");
        step(2'b00, 0, 0, 1, 16'h7FFF, 0, 0, 1, 0, 0, "R8 move with X write");
        idle("R9 idle hold");
        idle("R10 idle hold");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule